// File: doc/BRIEF.md
# Gated programmable clock divider

The block produces a train of one-cycle clock-enable pulses from its input clock. The pulses come at a rate that software sets through a small write port. A divisor register sets the division ratio. A separate enable register holds a single gate bit, which either lets the pulse train through or silences it. Downstream logic uses `tick_o` as a clock enable, or derives a slow clock from it.

The divisor field is `FIELD_W` bits wide. A field value of zero selects the largest ratio, which is 2^`FIELD_W`. An optional extended variant has a 6-bit field. In that variant the top field bit switches in a fixed divide-by-64 stage, which multiplies the low five bits, so slow peripheral clocks can be reached.

A divisor write first goes to a pending slot. It takes effect only at the end of the output period in progress, so no short period is ever produced. A busy flag in the read-only status word stays set until the change has landed.

Top module: `gated_clk_div`

## Requirements
- R1: With the extended stage off, a divisor field of 0 gives a pulse period of 2^FIELD_W cycles (32 for the default 5-bit field). In the extended variant a field of 0 gives 64 cycles.
- R2: A nonzero field N, with bit 5 clear in the extended variant, gives exactly one `tick_o` pulse every N cycles. N=1 gives a pulse on every cycle.
- R3: In the extended variant (EXT_MODE=1, FIELD_W=6), a field with bit 5 set gives a period of 64 times bits 4:0. When bits 4:0 are zero the period is 64.
- R4: `tick_o` pulses only while the enable bit is 1. While the enable bit is 0, `tick_o` stays low.
- R5: A write to the enable register (address 2) takes only data bit EN_BIT as the new enable. The other data bits have no effect.
- R6: A divisor write (address 1) sets busy in the cycle after the write. Busy appears as bits 4 and 3 of `status_o`, both set, and all other status bits are 0. Busy stays set until the new divisor is applied.
- R7: A new divisor is applied only when the current period ends. The period in progress completes at its old length, and the next period uses the new value.
- R8: Writes to address 0 (status) or address 3 change neither the divisor, the enable nor busy.
- R9: Reset clears the enable, the divisor field and the busy flag, and it restarts the counter from zero. With the enable set at reset release and a field of 0, the first pulse falls 2^FIELD_W-1 cycles after release (64-1 in the extended variant).
- R10: The period counter never reaches or exceeds the active divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 status, 1 divisor, 2 enable, 3 unused |
| wr_data_i | input | DATA_W | Write data |
| status_o | output | DATA_W | Status word; bits 4:3 are busy |
| tick_o | output | 1 | Gated one-cycle pulse at the divided rate |

## Verification
Four properties hold on every cycle: the counter stays below the active divisor, the active divisor changes only at a period boundary, busy rises after a divisor write and falls only at a boundary, and the enable changes only on an enable-register write. The bench alone shows that the measured pulse periods match the decoded divisor for plain, zero and prescaled fields in both widths. It also shows that a mid-period reprogram leaves the running period whole, and that gating, ignored writes and the first pulse after reset behave at the ports.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_DIV    = 2'd1,
    ADDR_EN     = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;

  localparam int BUSY_LO = 3;
  localparam int BUSY_HI = 4;
  localparam int EXT_W   = 6;   // field width of the prescaled variant
  localparam int PRE_SH  = 6;   // prescaler is 2**PRE_SH
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter int FIELD_W = 5,
  parameter bit EXT     = 1'b0,
  parameter int CNT_W   = FIELD_W + 1
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [CNT_W-1:0]   div_o
);
  import clkdiv_pkg::*;

  logic [CNT_W-1:0] raw;

  generate
    if (EXT) begin : g_ext
      // bit 5 set: low five bits scaled by the fixed prescaler
      assign raw   = field_i[EXT_W-1] ? CNT_W'({field_i[EXT_W-2:0], {PRE_SH{1'b0}}})
                                      : CNT_W'(field_i[EXT_W-2:0]);
      assign div_o = (raw == '0) ? CNT_W'(1 << EXT_W) : raw;
    end else begin : g_plain
      assign raw   = CNT_W'(field_i);
      assign div_o = (raw == '0) ? (CNT_W'(1) << FIELD_W) : raw;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int FIELD_W = 5,
  parameter bit EXT     = 1'b0,
  parameter int CNT_W   = FIELD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               busy_o,
  output logic               wrap_o
);
  logic [FIELD_W-1:0] act_q, pend_val_q;
  logic               pend_q;
  logic [CNT_W-1:0]   cnt_q, div_eff;

  clkdiv_decode #(.FIELD_W(FIELD_W), .EXT(EXT), .CNT_W(CNT_W)) u_dec (
    .field_i (act_q),
    .div_o   (div_eff)
  );

  assign wrap_o = (cnt_q == div_eff - CNT_W'(1));
  assign busy_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      act_q      <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else begin
      cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
      if (wrap_o && pend_q) act_q <= pend_val_q;
      // a write in the boundary cycle stays pending for the next boundary
      if (load_i) begin
        pend_q     <= 1'b1;
        pend_val_q <= field_i;
      end else if (wrap_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  a_r10_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_eff);
  a_r7_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> $stable(act_q));
  a_r6_busy_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
  a_r6_busy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(wrap_o));
endmodule

// File: rtl/gated_clk_div.sv
module gated_clk_div
  import clkdiv_pkg::*;
#(
  parameter int FIELD_W  = 5,
  parameter bit EXT_MODE = 1'b0,
  parameter int DATA_W   = 8,
  parameter int EN_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] status_o,
  output logic              tick_o
);
  localparam bit EXT   = EXT_MODE && (FIELD_W == EXT_W);
  localparam int CNT_W = EXT ? (EXT_W + PRE_SH - 1) : FIELD_W + 1;

  logic wr_div, wr_en_reg, wr_status;
  logic en_q, busy, wrap;
  logic unused_data;

  assign wr_div    = wr_en_i && (wr_addr_i == ADDR_DIV);
  assign wr_en_reg = wr_en_i && (wr_addr_i == ADDR_EN);
  assign wr_status = wr_en_i && (wr_addr_i == ADDR_STATUS);
  assign unused_data = ^wr_data_i;

  clkdiv_counter #(.FIELD_W(FIELD_W), .EXT(EXT), .CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr_div),
    .field_i (wr_data_i[FIELD_W-1:0]),
    .busy_o  (busy),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (wr_en_reg) en_q <= wr_data_i[EN_BIT];
  end

  always_comb begin
    status_o          = '0;
    status_o[BUSY_HI] = busy;
    status_o[BUSY_LO] = busy;
  end

  assign tick_o = en_q && wrap;

  a_r5_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_reg |=> $stable(en_q));
  a_r8_status_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && !busy) |=> !busy);
endmodule

// File: tb/gated_clk_div_tb_top.sv
`timescale 1ns/1ps
module gated_clk_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] st6, st5;
  logic       t6, t5;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  gated_clk_div #(.FIELD_W(6), .EXT_MODE(1'b1), .DATA_W(8), .EN_BIT(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .status_o(st6), .tick_o(t6));

  gated_clk_div #(.FIELD_W(5), .EXT_MODE(1'b0), .DATA_W(8), .EN_BIT(3)) dut5_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .status_o(st5), .tick_o(t5));

  // {field, period 6-bit prescaled dut, period 5-bit dut}
  localparam logic [23:0] VEC [8] = '{
    {6'h00, 12'd64,   6'd32},
    {6'h01, 12'd1,    6'd1},
    {6'h1F, 12'd31,   6'd31},
    {6'h21, 12'd64,   6'd1},
    {6'h23, 12'd192,  6'd3},
    {6'h20, 12'd64,   6'd32},
    {6'h10, 12'd16,   6'd16},
    {6'h3F, 12'd1984, 6'd31}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      if (st6[4:3] == 2'b00 && st5[4:3] == 2'b00) break;
      @(negedge clk);
    end
  endtask

  task automatic measure(input bit sel5, output int p);
    int i;
    p = -1;
    for (i = 0; i < 5000; i++) begin
      @(negedge clk);
      if ((sel5 ? t5 : t6) == 1'b1) break;
    end
    for (int k = 1; k < 5000; k++) begin
      @(negedge clk);
      if ((sel5 ? t5 : t6) == 1'b1) begin p = k; break; end
    end
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (t6 || t5) c++;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p, c, f5, f6;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 status6 in reset", st6, 0);
    chk("R9 status5 in reset", st5, 0);
    chk("R9 tick in reset", t6 | t5, 0);
    // R9 release with enable written: counter restarts from zero
    rst_n = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h08;
    f5 = -1; f6 = -1;
    for (int k = 1; k <= 70; k++) begin
      @(negedge clk);
      if (k == 1) wr_en = 1'b0;
      if (t5 && f5 < 0) f5 = k;
      if (t6 && f6 < 0) f6 = k;
    end
    chk("R9 R1 first tick 5-bit", f5, 31);
    chk("R9 R1 first tick prescaled variant", f6, 63);

    // R1 R2 R3 period table
    foreach (VEC[i]) begin
      wr(2'd1, {2'b00, VEC[i][23:18]});
      chk("R6 busy bits after divisor write", st6, 8'h18);
      wait_idle();
      measure(1'b0, p);
      chk("R1 R2 R3 period prescaled variant", p, int'(VEC[i][17:6]));
      measure(1'b1, p);
      chk("R1 R2 period 5-bit", p, int'(VEC[i][5:0]));
    end

    // R7 mid-period reprogram on the prescaled variant: 20 -> 10
    wr(2'd1, 8'd20);
    wait_idle();
    measure(1'b0, p);
    chk("R7 setup period", p, 20);
    p = -1;
    for (int k = 1; k < 100; k++) begin
      @(negedge clk);
      if (k == 5) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd10; end
      if (k == 6) begin
        wr_en = 1'b0;
        chk("R6 busy during pending update", st6[4:3], 2'b11);
      end
      if (t6) begin
        p = k;
        chk("R6 busy held to boundary", st6[4:3], 2'b11);
        break;
      end
    end
    chk("R7 running period kept", p, 20);
    @(negedge clk);
    chk("R6 busy cleared after apply", st6[4:3], 2'b00);
    measure(1'b0, p);
    chk("R7 new period", p, 10);

    // R8 writes to status and unused address ignored
    wr(2'd1, 8'h1F);
    wait_idle();
    wr(2'd0, 8'hFF);
    chk("R8 status write ignored", st6, 0);
    wr(2'd3, 8'h02);
    chk("R8 unused address write ignored", st6, 0);
    measure(1'b0, p);
    chk("R8 period unchanged", p, 31);

    // R5 other enable bits have no effect, R4 gating
    wr(2'd2, 8'hFF);
    measure(1'b0, p);
    chk("R5 enable with other bits set", p, 31);
    wr(2'd2, 8'hF7);
    count_ticks(200, c);
    chk("R4 R5 gated off, no pulses", c, 0);
    wr(2'd2, 8'h08);
    measure(1'b0, p);
    chk("R4 pulses resume", p, 31);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule